// File: doc/BRIEF.md
# Byte Bit-Manipulation Execution Unit

This unit carries out four single-bit operations for a small 32-bit processor core: setting one bit of a byte in memory, clearing one bit of a byte in memory, testing one bit of a register, and clearing chosen flags in the processor status word. The decode stage presents an opcode, a 3-bit bit index, an 8-bit immediate, a base register value and a signed 16-bit offset, together with a one-cycle `start` strobe.

The two memory forms add the sign-extended offset to the base and read one byte over a request/ready port. They change the selected bit and write the byte back to the same address. The register test and the flag clear finish in one cycle. They return a new condition bit, or a new status word, with a write-enable strobe for the core to latch. Bits are numbered from the most significant end of the byte, so index 0 names bit 7.

Top module: `bit_manip_unit`

## Requirements
- R1: The bit index selects byte bit (7 - index); index 0 is bit 7 and index 7 is bit 0.
- R2: Opcode 2'b00 (bit set) reads the byte at the effective address, ORs in the selected bit, and writes the result back to the same address.
- R3: Opcode 2'b01 (bit clear) reads the byte at the effective address, clears the selected bit, and writes the result back. The other seven bits of the byte are unchanged.
- R4: The effective address is `base` plus `offset` sign-extended to 32 bits.
- R5: Opcode 2'b10 (bit test) drives `cond_out` to bit (7 - index) of the low byte of `base` and pulses `cond_we`. Base bits above bit 7 have no effect, and no memory request is made.
- R6: Opcode 2'b11 (flag clear) drives `psw_out` = `psw_in` AND ({8'hFF, NOT `imm8`}) and pulses `psw_we`. Bits 15:8 of the status word pass through unchanged.
- R7: A memory operation makes exactly one read handshake (`mem_we`=0) followed by exactly one write handshake (`mem_we`=1). A handshake completes on a cycle where `mem_req` and `mem_ready` are both high. While a request waits for ready, the request, address and direction stay stable.
- R8: `done` is high for exactly one cycle per operation. For bit test and flag clear it is high in the cycle after `start`.
- R9: A `start` while a memory operation is in progress has no effect. No extra memory access, condition update or status update follows from it.
- R10: The synchronous active-low reset `rst_n` aborts any operation. While reset is low and after it is released, `mem_req`, `done`, `cond_we` and `psw_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin an operation with the current operands |
| opcode | input | 2 | 00 bit set, 01 bit clear, 10 bit test, 11 flag clear |
| bit_idx | input | 3 | Bit index, MSB-first within the byte |
| imm8 | input | 8 | Flags to clear (flag clear only) |
| base | input | 32 | Base register value, or source register for bit test |
| offset | input | 16 | Signed address offset |
| psw_in | input | 16 | Current status word |
| mem_rdata | input | 8 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Memory handshake completion |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 8 | Write data |
| cond_out | output | 1 | New condition bit |
| cond_we | output | 1 | Condition bit write strobe |
| psw_out | output | 16 | New status word |
| psw_we | output | 1 | Status word write strobe |
| done | output | 1 | Operation finished |

## Verification
The assertions assume that `mem_ready` means something only while `mem_req` is high, and that `mem_rdata` is valid in the cycle the read handshake completes. They also assume that `psw_in` is valid in the cycle `start` is sampled. The bench memory model raises ready only against an active request, after a chosen wait count. It returns the byte stored at the low address bits in that same cycle. Operands are driven on the falling edge and held through the `start` cycle, so they are stable when the unit samples them.

// File: rtl/bmu_pkg.sv
// Package: shared opcode and sequencer state types for the bit-manipulation unit.
// Assumes a 2-bit opcode whose upper bit separates memory from register forms.
package bmu_pkg;
    typedef enum logic [1:0] {
        OP_BSET = 2'b00,
        OP_BCLR = 2'b01,
        OP_BTST = 2'b10,
        OP_FCLR = 2'b11
    } bmu_op_e;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_READ       = 3'd1,
        ST_WAIT_READ  = 3'd2,
        ST_WRITE      = 3'd3,
        ST_WAIT_WRITE = 3'd4,
        ST_DONE       = 3'd5
    } bmu_state_e;
endpackage

// File: rtl/bmu_mask.sv
// Module: bmu_mask
// Turns a bit index into a one-hot byte mask, numbered from the MSB
// (index 0 -> bit BYTE_W-1). Assumes BYTE_W is a power of two.
module bmu_mask #(
    parameter int BYTE_W = 8,
    localparam int IDX_W = $clog2(BYTE_W)
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [BYTE_W-1:0] mask
);
    // One comparator per mask bit: bit g is chosen by index BYTE_W-1-g.
    for (genvar g = 0; g < BYTE_W; g++) begin : g_bit
        localparam logic [IDX_W-1:0] SEL = IDX_W'(BYTE_W - 1 - g);
        assign mask[g] = (idx == SEL);
    end

    // R1: exactly one bit of the byte is ever selected.
    always_comb begin
        assert_mask_onehot_R1: assert ($countones(mask) == 1 || $isunknown(idx));
    end
endmodule

// File: rtl/bmu_addr.sv
// Module: bmu_addr
// Effective address: base plus sign-extended offset. Pure combinational.
module bmu_addr #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [OFF_W-1:0]  offset,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] off_ext;

    // Replicate the offset sign bit up to address width, then add.
    always_comb begin
        off_ext = {{(ADDR_W-OFF_W){offset[OFF_W-1]}}, offset};
        addr    = base + off_ext;
    end
endmodule

// File: rtl/bmu_mem_seq.sv
// Module: bmu_mem_seq
// Read-modify-write sequencer for one byte. It latches address, mask and
// set/clear on go, reads, modifies and writes back, then signals done for
// one cycle. Assumes go is raised only while busy is low, and that mem_rdata
// is valid in the cycle of the read handshake.
module bmu_mem_seq
    import bmu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              is_clr,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [BYTE_W-1:0] mask_in,
    input  logic [BYTE_W-1:0] mem_rdata,
    input  logic              mem_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              busy,
    output logic              done_mem
);
    bmu_state_e        state, state_nx;
    logic [ADDR_W-1:0] addr_q;
    logic [BYTE_W-1:0] mask_q;
    logic [BYTE_W-1:0] rdata_q;
    logic [BYTE_W-1:0] wdata_q;
    logic              clr_q;
    logic              rd_hs;

    // Next-state selection for the read-modify-write sequence.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:       if (go) state_nx = ST_READ;
            ST_READ:       state_nx = mem_ready ? ST_WRITE : ST_WAIT_READ;
            ST_WAIT_READ:  if (mem_ready) state_nx = ST_WRITE;
            ST_WRITE:      state_nx = mem_ready ? ST_DONE : ST_WAIT_WRITE;
            ST_WAIT_WRITE: if (mem_ready) state_nx = ST_DONE;
            ST_DONE:       state_nx = ST_IDLE;
            default:       state_nx = ST_IDLE;
        endcase
    end

    // Read handshake: any read state with ready high.
    assign rd_hs = mem_ready && (state == ST_READ || state == ST_WAIT_READ);

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Operand capture on acceptance; read data and modified byte on read handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            mask_q  <= '0;
            clr_q   <= 1'b0;
            rdata_q <= '0;
            wdata_q <= '0;
        end else begin
            if (state == ST_IDLE && go) begin
                addr_q <= addr_in;
                mask_q <= mask_in;
                clr_q  <= is_clr;
            end
            if (rd_hs) begin
                rdata_q <= mem_rdata;
                wdata_q <= clr_q ? (mem_rdata & ~mask_q) : (mem_rdata | mask_q);
            end
        end
    end

    // Port drive decoded from the state register.
    always_comb begin
        mem_req   = (state == ST_READ) || (state == ST_WAIT_READ) ||
                    (state == ST_WRITE) || (state == ST_WAIT_WRITE);
        mem_we    = (state == ST_WRITE) || (state == ST_WAIT_WRITE);
        mem_addr  = addr_q;
        mem_wdata = wdata_q;
        busy      = (state != ST_IDLE);
        done_mem  = (state == ST_DONE);
    end

    // R7: a pending request holds its address and direction until ready.
    assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)));

    // R7: a write always follows a completed read.
    assert_write_after_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ready) |=> (mem_req && mem_we));

    // R3: write data differs from the byte read only at the selected bit.
    assert_byte_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (((mem_wdata ^ rdata_q) & ~mask_q) == '0));

    // R8: the memory completion strobe lasts one cycle.
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_mem |=> !done_mem);
endmodule

// File: rtl/bit_manip_unit.sv
// Module: bit_manip_unit
// Top of the byte bit-manipulation unit. It accepts an operation on start when
// idle, and hands the memory forms to the read-modify-write sequencer. It
// finishes bit test and flag clear in one registered cycle. Assumes operands
// and psw_in are valid in the cycle start is sampled.
module bit_manip_unit
    import bmu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16,
    parameter int BYTE_W = 8,
    parameter int PSW_W  = 16,
    localparam int IDX_W = $clog2(BYTE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        opcode,
    input  logic [IDX_W-1:0]  bit_idx,
    input  logic [BYTE_W-1:0] imm8,
    input  logic [ADDR_W-1:0] base,
    input  logic [OFF_W-1:0]  offset,
    input  logic [PSW_W-1:0]  psw_in,
    input  logic [BYTE_W-1:0] mem_rdata,
    input  logic              mem_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              cond_out,
    output logic              cond_we,
    output logic [PSW_W-1:0]  psw_out,
    output logic              psw_we,
    output logic              done
);
    logic [BYTE_W-1:0] bit_mask;
    logic [ADDR_W-1:0] eff_addr;
    logic              busy;
    logic              done_mem;
    logic              accept;
    logic              go_mem;
    logic              quick_done;
    logic              test_bit;
    logic [PSW_W-1:0]  psw_new;
    bmu_op_e           op;

    assign op = bmu_op_e'(opcode);

    bmu_mask #(.BYTE_W(BYTE_W)) u_mask (
        .idx  (bit_idx),
        .mask (bit_mask)
    );

    bmu_addr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_addr (
        .base   (base),
        .offset (offset),
        .addr   (eff_addr)
    );

    // Acceptance, bit extraction and status-word masking.
    always_comb begin
        accept   = start && !busy;
        go_mem   = accept && (op == OP_BSET || op == OP_BCLR);
        test_bit = |(base[BYTE_W-1:0] & bit_mask);
        psw_new  = psw_in & {{(PSW_W-BYTE_W){1'b1}}, ~imm8};
    end

    bmu_mem_seq #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go_mem),
        .is_clr    (op == OP_BCLR),
        .addr_in   (eff_addr),
        .mask_in   (bit_mask),
        .mem_rdata (mem_rdata),
        .mem_ready (mem_ready),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .busy      (busy),
        .done_mem  (done_mem)
    );

    // Single-cycle results for bit test and flag clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cond_out   <= 1'b0;
            cond_we    <= 1'b0;
            psw_out    <= '0;
            psw_we     <= 1'b0;
            quick_done <= 1'b0;
        end else begin
            cond_we    <= accept && (op == OP_BTST);
            psw_we     <= accept && (op == OP_FCLR);
            quick_done <= accept && (op == OP_BTST || op == OP_FCLR);
            if (accept && op == OP_BTST) cond_out <= test_bit;
            if (accept && op == OP_FCLR) psw_out  <= psw_new;
        end
    end

    assign done = quick_done | done_mem;

    // R6: the upper status-word bits are copied from the sampled input.
    assert_psw_upper_R6: assert property (@(posedge clk) disable iff (!rst_n)
        psw_we |-> (psw_out[PSW_W-1:BYTE_W] == $past(psw_in[PSW_W-1:BYTE_W])));

    // R9: a start during a memory operation produces no register-form result.
    assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (!cond_we && !psw_we));

    // R8: the two completion sources never coincide.
    assert_done_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(quick_done && done_mem));

    // R5: bit test never issues a memory request in its result cycle.
    assert_test_no_mem_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cond_we |-> !mem_req);
endmodule

// File: tb/bit_manip_unit_tb.sv
module bit_manip_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  opcode = 2'b00;
    logic [2:0]  bit_idx = 3'd0;
    logic [7:0]  imm8 = 8'h00;
    logic [31:0] base = 32'h0;
    logic [15:0] offset = 16'h0;
    logic [15:0] psw_in = 16'h0;
    logic [7:0]  mem_rdata;
    logic        mem_ready;
    logic        mem_req, mem_we, cond_out, cond_we, psw_we, done;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [15:0] psw_out;

    int checks = 0;
    int fails  = 0;
    int lat    = 0;
    int wcnt   = 0;
    int n_rd = 0, n_wr = 0, n_cwe = 0, order_err = 0;
    logic        rd_seen = 1'b0;
    logic [31:0] last_rd_addr = 32'h0, last_wr_addr = 32'h0;
    logic [7:0]  mem [0:255];

    always #5 clk = ~clk;

    bit_manip_unit u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .bit_idx(bit_idx), .imm8(imm8), .base(base), .offset(offset),
        .psw_in(psw_in), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .cond_out(cond_out), .cond_we(cond_we),
        .psw_out(psw_out), .psw_we(psw_we), .done(done)
    );

    // Memory model: ready after lat waiting cycles, byte array on low address bits.
    assign mem_ready = mem_req && (wcnt >= lat);
    assign mem_rdata = mem[mem_addr[7:0]];

    always @(posedge clk) begin
        if (!rst_n || !mem_req || mem_ready) wcnt <= 0;
        else wcnt <= wcnt + 1;
        if (mem_req && mem_ready) begin
            if (mem_we) begin
                mem[mem_addr[7:0]] <= mem_wdata;
                n_wr <= n_wr + 1;
                last_wr_addr <= mem_addr;
                if (!rd_seen) order_err <= order_err + 1;
            end else begin
                n_rd <= n_rd + 1;
                last_rd_addr <= mem_addr;
                rd_seen <= 1'b1;
            end
        end
        if (cond_we) n_cwe <= n_cwe + 1;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic launch(input logic [1:0] op, input logic [2:0] idx,
                          input logic [31:0] b, input logic [15:0] off);
        @(negedge clk);
        opcode = op; bit_idx = idx; base = b; offset = off; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output int cyc);
        cyc = 0;
        while (!done && cyc < 60) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    // Memory form: preset byte, run, check byte, addresses, handshake counts, done pulse.
    task automatic t_mem(input string req, input logic [1:0] op, input logic [2:0] idx,
                         input logic [31:0] b, input logic [15:0] off,
                         input logic [31:0] exp_addr, input logic [7:0] pre,
                         input logic [7:0] exp);
        int rd0, wr0, cyc;
        mem[exp_addr[7:0]] = pre;
        rd_seen = 1'b0;
        rd0 = n_rd; wr0 = n_wr;
        launch(op, idx, b, off);
        wait_done(cyc);
        check({req, " done seen"}, {31'd0, done}, 32'd1);
        @(negedge clk);
        check({req, " R8 done one cycle"}, {31'd0, done}, 32'd0);
        check({req, " byte"}, {24'd0, mem[exp_addr[7:0]]}, {24'd0, exp});
        check({req, " R4 read addr"}, last_rd_addr, exp_addr);
        check({req, " R4 write addr"}, last_wr_addr, exp_addr);
        check({req, " R7 one read one write"}, (n_rd - rd0) * 16 + (n_wr - wr0), 32'h11);
        check({req, " R7 read before write"}, order_err, 32'd0);
    endtask

    // Bit test: result in the cycle after start, no memory traffic.
    task automatic t_test(input logic [2:0] idx, input logic [31:0] b, input logic exp);
        int rd0;
        rd0 = n_rd;
        launch(2'b10, idx, b, 16'h0);
        check("R5 cond_we", {31'd0, cond_we}, 32'd1);
        check("R8 done next cycle (test)", {31'd0, done}, 32'd1);
        check("R5 R1 cond_out", {31'd0, cond_out}, {31'd0, exp});
        @(negedge clk);
        check("R5 no memory read", n_rd - rd0, 32'd0);
        check("R8 done drops (test)", {31'd0, done}, 32'd0);
    endtask

    // Flag clear: masked status word one cycle after start.
    task automatic t_flags(input logic [15:0] p, input logic [7:0] m, input logic [15:0] exp);
        @(negedge clk);
        opcode = 2'b11; imm8 = m; psw_in = p; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        psw_in = 16'h0;
        check("R6 psw_we", {31'd0, psw_we}, 32'd1);
        check("R6 psw_out", {16'd0, psw_out}, {16'd0, exp});
        check("R8 done next cycle (flags)", {31'd0, done}, 32'd1);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R10 mem_req in reset", {31'd0, mem_req}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 outputs idle after reset",
              {28'd0, mem_req, done, cond_we, psw_we}, 32'd0);
    endtask

    // A start during a slow memory operation must change nothing.
    task automatic t_busy;
        int wr0, cwe0, cyc;
        lat = 4;
        mem[8'h33] = 8'h00;
        mem[8'h44] = 8'h55;
        wr0 = n_wr; cwe0 = n_cwe;
        launch(2'b00, 3'd3, 32'h0000_0033, 16'h0000);
        @(negedge clk);
        opcode = 2'b10; bit_idx = 3'd7; base = 32'h0000_0001; start = 1'b1;
        @(negedge clk);
        opcode = 2'b01; base = 32'h0000_0044; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(cyc);
        repeat (3) @(negedge clk);
        check("R9 no condition update", n_cwe - cwe0, 32'd0);
        check("R9 single write", n_wr - wr0, 32'd1);
        check("R9 first op result", {24'd0, mem[8'h33]}, 32'h10);
        check("R9 other byte untouched", {24'd0, mem[8'h44]}, 32'h55);
        lat = 0;
    endtask

    // Reset in the middle of a memory operation aborts it.
    task automatic t_reset_mid;
        int wr0;
        lat = 6;
        mem[8'h66] = 8'h00;
        wr0 = n_wr;
        launch(2'b00, 3'd0, 32'h0000_0066, 16'h0000);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 abort drops request", {31'd0, mem_req}, 32'd0);
        rst_n = 1'b1;
        lat = 0;
        repeat (8) @(negedge clk);
        check("R10 no write after abort", n_wr - wr0, 32'd0);
        check("R10 idle after abort", {30'd0, mem_req, done}, 32'd0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        t_reset();
        lat = 0;
        t_mem("R1 R2 set idx0", 2'b00, 3'd0, 32'h0000_0020, 16'h0000, 32'h0000_0020, 8'h00, 8'h80);
        lat = 3;
        t_mem("R2 set idx5 slow", 2'b00, 3'd5, 32'h0000_0030, 16'h0001, 32'h0000_0031, 8'hAA, 8'hAE);
        lat = 1;
        t_mem("R3 clear idx7", 2'b01, 3'd7, 32'h0000_0050, 16'h0002, 32'h0000_0052, 8'hFF, 8'hFE);
        lat = 0;
        t_mem("R3 clear already clear", 2'b01, 3'd0, 32'h0000_0060, 16'h0000, 32'h0000_0060, 8'h7F, 8'h7F);
        t_mem("R4 negative offset", 2'b00, 3'd7, 32'h0000_0150, 16'hFFF0, 32'h0000_0140, 8'h00, 8'h01);
        t_mem("R4 max positive offset", 2'b01, 3'd4, 32'h1000_0000, 16'h7FFF, 32'h1000_7FFF, 8'hFF, 8'hF7);
        t_test(3'd0, 32'h1234_5680, 1'b1);
        t_test(3'd7, 32'h1234_5680, 1'b0);
        t_test(3'd7, 32'h0000_0001, 1'b1);
        t_test(3'd3, 32'hFFFF_FF00, 1'b0);
        t_flags(16'hA5C3, 8'h81, 16'hA542);
        t_flags(16'hA5C3, 8'hFF, 16'hA500);
        t_flags(16'hFFFF, 8'h00, 16'hFFFF);
        t_busy();
        t_reset_mid();
        t_mem("R10 R2 op after abort", 2'b00, 3'd1, 32'h0000_0070, 16'h0000, 32'h0000_0070, 8'h00, 8'h40);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #1_000_000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule